// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit prepares the address and data for a single-register load or store. From a base value, an offset and an indexing mode it forms the memory address. It also forms the value to write back into the base register, with an enable for that writeback. The offset is either a zero-extended immediate or a register value shifted left by a small amount, and it can be added to or subtracted from the base. For stores it places the data on the correct byte lanes and raises only the byte enables of the bytes being written. For loads it picks the addressed byte or halfword out of the returned word, then sign-extends or zero-extends it to 32 bits.

Every access except a doubleword is handled in the cycle in which it is requested, so all outputs follow the inputs combinationally. A doubleword access runs through a two-state controller. State `IDLE` issues the low word and takes transition `START_DW` into state `DW_HI`. State `DW_HI` issues the high word at the address plus 4 with `busy` raised, then takes transition `DW_DONE` back to `IDLE`. Any request presented while in `DW_HI` is dropped. The memory is assumed to return `mem_rdata` in the same cycle as the address.

Top module: `lsagu_top`

## Requirements
- R1: With `req_mode`=0 (plain offset), `mem_addr` is `base_val` plus or minus the offset, and `wb_en` stays 0.
- R2: The offset is `off_imm`, zero-extended, when `off_sel_reg`=0. When `off_sel_reg`=1 it is `off_reg_val` shifted left by `off_shift`.
- R3: `req_sub`=1 subtracts the offset from the base; `req_sub`=0 adds it.
- R4: With `req_mode`=1 (pre-index with writeback), `mem_addr` is base±offset, `wb_en`=1, and `wb_value` equals that same address.
- R5: With `req_mode`=2 (post-index), `mem_addr` is the unmodified base, `wb_en`=1, and `wb_value` is base±offset.
- R6: Size codes are 0 word, 1 unsigned byte, 2 signed byte, 3 unsigned halfword, 4 signed halfword and 5 doubleword. On a store, `mem_be` is 4'b1111 for a word. For a halfword it is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. For a byte it is 4'b0001 shifted left by address bits 1:0. On a load, and when idle, `mem_be` is 0.
- R7: A load of a byte or halfword takes the lane selected by the low address bits (little-endian). Sizes 2 and 4 sign-extend it to 32 bits on `ld_value`; sizes 1 and 3 zero-extend it. A word load returns `mem_rdata` unchanged.
- R8: A byte store repeats `st_lo[7:0]` on all four lanes of `mem_wdata`, and a halfword store repeats `st_lo[15:0]` on both halves.
- R9: A doubleword takes two cycles. The first cycle accesses the computed address with `st_lo` and `busy`=0. The next cycle accesses that address plus 4 with `st_hi` (as captured at the request), `mem_be`=4'b1111 for a store, and `busy`=1. `busy` then returns to 0.
- R10: While `busy`=1, the request inputs are ignored: `wb_en` is 0, the address and data come from the captured doubleword, and a request held during that cycle is not started afterwards.
- R11: After reset, `busy`=0, and with `req_valid`=0 both `mem_en` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access requested this cycle |
| req_load | input | 1 | 1 load, 0 store |
| req_size | input | 3 | Access size code |
| req_mode | input | 2 | 0 offset, 1 pre-index writeback, 2 post-index |
| req_sub | input | 1 | Subtract offset from base |
| off_sel_reg | input | 1 | Use register offset instead of immediate |
| off_shift | input | 2 | Left shift applied to register offset |
| off_imm | input | 12 | Immediate offset |
| base_val | input | 32 | Base register value |
| off_reg_val | input | 32 | Offset register value |
| st_lo | input | 32 | Store data (low word for doubleword) |
| st_hi | input | 32 | High store word for doubleword |
| mem_rdata | input | 32 | Read data returned by memory |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory address |
| mem_be | output | 4 | Store byte enables |
| mem_wdata | output | 32 | Lane-aligned store data |
| ld_value | output | 32 | Extended load result |
| wb_en | output | 1 | Base writeback enable |
| wb_value | output | 32 | Base writeback value |
| busy | output | 1 | Second doubleword cycle in progress |

## Verification
The only internal state is the doubleword controller and its captured address, direction and high word. A wrong state therefore shows at the ports within one cycle of a doubleword request. It appears as a missing or stuck `busy`, a second address that is not the first plus 4, the wrong high data word, or a writeback or new access leaking through while `busy` is high. Errors in the combinational paths show in the same cycle as the request, on the address, the writeback, the byte enables or the extended load value. The directed cases target the lanes at the ends of the word and values with the sign bit set.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;

    typedef enum logic [2:0] {
        SZ_WORD  = 3'd0,
        SZ_UBYTE = 3'd1,
        SZ_SBYTE = 3'd2,
        SZ_UHALF = 3'd3,
        SZ_SHALF = 3'd4,
        SZ_DWORD = 3'd5
    } size_e;

    typedef enum logic [1:0] {
        IX_OFFSET = 2'd0,
        IX_PRE    = 2'd1,
        IX_POST   = 2'd2,
        IX_RSVD   = 2'd3
    } idx_e;

    typedef enum logic {
        IDLE  = 1'b0,
        DW_HI = 1'b1
    } seq_state_e;
endpackage

// File: rtl/lsagu_addr.sv
module lsagu_addr
    import lsagu_pkg::*;
#(
    parameter int IMM_W = 12,
    parameter int SH_W  = 2
) (
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  reg_off,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_reg,
    input  logic [SH_W-1:0]  shamt,
    input  logic             sub,
    input  idx_e             mode,
    output logic [XLEN-1:0]  addr,
    output logic             wb_req,
    output logic [XLEN-1:0]  wb_val
);
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] sum;

    always_comb begin
        offset = use_reg ? (reg_off << shamt) : XLEN'(imm);
        sum    = sub ? (base - offset) : (base + offset);
        unique case (mode)
            IX_PRE: begin
                addr   = sum;
                wb_req = 1'b1;
                wb_val = sum;
            end
            IX_POST: begin
                addr   = base;
                wb_req = 1'b1;
                wb_val = sum;
            end
            default: begin
                addr   = sum;
                wb_req = 1'b0;
                wb_val = base;
            end
        endcase
    end
endmodule

// File: rtl/lsagu_lane.sv
module lsagu_lane
    import lsagu_pkg::*;
(
    input  size_e            size,
    input  logic [1:0]       lo,
    input  logic [XLEN-1:0]  st_data,
    input  logic [XLEN-1:0]  rdata,
    output logic [LANES-1:0] be,
    output logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  ld_val
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        byte_sel = rdata[8*lo +: 8];
        half_sel = lo[1] ? rdata[31:16] : rdata[15:0];
        be       = '1;
        wdata    = st_data;
        ld_val   = rdata;
        unique case (size)
            SZ_UBYTE, SZ_SBYTE: begin
                be     = LANES'(1) << lo;
                wdata  = {LANES{st_data[7:0]}};
                ld_val = (size == SZ_SBYTE) ? {{(XLEN-8){byte_sel[7]}}, byte_sel}
                                            : {{(XLEN-8){1'b0}}, byte_sel};
            end
            SZ_UHALF, SZ_SHALF: begin
                be     = lo[1] ? 4'b1100 : 4'b0011;
                wdata  = {2{st_data[15:0]}};
                ld_val = (size == SZ_SHALF) ? {{(XLEN-16){half_sel[15]}}, half_sel}
                                            : {{(XLEN-16){1'b0}}, half_sel};
            end
            default: ;
        endcase
    end

    // R6
    always_comb begin
        if (size == SZ_UBYTE || size == SZ_SBYTE)
            byte_lane_onehot_chk: assert ($countones(be) == 1);
    end
endmodule

// File: rtl/lsagu_seq.sv
module lsagu_seq
    import lsagu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XLEN-1:0] lo_addr,
    input  logic            lo_load,
    input  logic [XLEN-1:0] hi_data_in,
    output logic            busy,
    output logic [XLEN-1:0] hi_addr,
    output logic            hi_load,
    output logic [XLEN-1:0] hi_data
);
    seq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE:  if (start) state_nx = DW_HI;
            DW_HI: state_nx = IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= IDLE;
            hi_addr <= '0;
            hi_load <= 1'b0;
            hi_data <= '0;
        end else begin
            state <= state_nx;
            if (state == IDLE && start) begin
                hi_addr <= lo_addr + XLEN'(4);
                hi_load <= lo_load;
                hi_data <= hi_data_in;
            end
        end
    end

    always_comb busy = (state == DW_HI);

    // R9
    dw_second_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(start));
    // R9
    dw_busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
    import lsagu_pkg::*;
#(
    parameter int IMM_W = 12,
    parameter int SH_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_load,
    input  logic [2:0]       req_size,
    input  logic [1:0]       req_mode,
    input  logic             req_sub,
    input  logic             off_sel_reg,
    input  logic [SH_W-1:0]  off_shift,
    input  logic [IMM_W-1:0] off_imm,
    input  logic [31:0]      base_val,
    input  logic [31:0]      off_reg_val,
    input  logic [31:0]      st_lo,
    input  logic [31:0]      st_hi,
    input  logic [31:0]      mem_rdata,
    output logic             mem_en,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    output logic [31:0]      ld_value,
    output logic             wb_en,
    output logic [31:0]      wb_value,
    output logic             busy
);
    size_e            size;
    idx_e             mode;
    logic [XLEN-1:0]  ea;
    logic             wb_req;
    logic [XLEN-1:0]  wb_sum;
    logic [LANES-1:0] lane_be;
    logic [XLEN-1:0]  lane_wdata;
    logic [XLEN-1:0]  lane_ld;
    logic             dw_start;
    logic [XLEN-1:0]  hi_addr;
    logic             hi_load;
    logic [XLEN-1:0]  hi_data;

    always_comb begin
        size     = size_e'(req_size);
        mode     = idx_e'(req_mode);
        dw_start = req_valid && !busy && (size == SZ_DWORD);
    end

    lsagu_addr #(.IMM_W(IMM_W), .SH_W(SH_W)) u_addr (
        .base(base_val), .reg_off(off_reg_val), .imm(off_imm),
        .use_reg(off_sel_reg), .shamt(off_shift), .sub(req_sub), .mode(mode),
        .addr(ea), .wb_req(wb_req), .wb_val(wb_sum)
    );

    lsagu_lane u_lane (
        .size(size), .lo(ea[1:0]), .st_data(st_lo), .rdata(mem_rdata),
        .be(lane_be), .wdata(lane_wdata), .ld_val(lane_ld)
    );

    lsagu_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(dw_start), .lo_addr(ea),
        .lo_load(req_load), .hi_data_in(st_hi), .busy(busy),
        .hi_addr(hi_addr), .hi_load(hi_load), .hi_data(hi_data)
    );

    always_comb begin
        if (busy) begin
            mem_en    = 1'b1;
            mem_we    = !hi_load;
            mem_addr  = hi_addr;
            mem_be    = hi_load ? '0 : '1;
            mem_wdata = hi_data;
            ld_value  = mem_rdata;
            wb_en     = 1'b0;
        end else begin
            mem_en    = req_valid;
            mem_we    = req_valid && !req_load;
            mem_addr  = ea;
            mem_be    = (req_valid && !req_load) ? lane_be : '0;
            mem_wdata = lane_wdata;
            ld_value  = lane_ld;
            wb_en     = req_valid && wb_req;
        end
        wb_value = wb_sum;
    end

    // R10
    no_wb_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wb_en);
    // R9
    dw_hi_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_addr == $past(mem_addr) + 32'd4);
    // R5
    post_uses_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_mode == 2'd2) |-> (mem_addr == base_val && wb_en));
    // R6
    load_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (mem_be == 4'b0000));
endmodule

// File: tb/tb_lsagu_top.sv
`timescale 1ns/1ps
module tb_lsagu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_load, req_sub, off_sel_reg;
    logic [2:0]  req_size;
    logic [1:0]  req_mode, off_shift;
    logic [11:0] off_imm;
    logic [31:0] base_val, off_reg_val, st_lo, st_hi, mem_rdata;
    logic        mem_en, mem_we, wb_en, busy;
    logic [31:0] mem_addr, mem_wdata, ld_value, wb_value;
    logic [3:0]  mem_be;

    int n_chk = 0;
    int n_bad = 0;

    lsagu_top dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_load = 0; req_sub = 0; off_sel_reg = 0;
        req_size = 0; req_mode = 0; off_shift = 0; off_imm = 0;
        base_val = 0; off_reg_val = 0; st_lo = 0; st_hi = 0; mem_rdata = 0;
    endtask

    task automatic t_reset();
        @(negedge clk); idle(); #1;
        chk("R11 busy", {31'd0, busy}, 0);
        chk("R11 mem_en", {31'd0, mem_en}, 0);
        chk("R11 wb_en", {31'd0, wb_en}, 0);
    endtask

    task automatic t_offset();
        @(negedge clk); idle();
        req_valid = 1; req_load = 1; base_val = 32'h1000; off_imm = 12'hFFC;
        #1;
        chk("R1 addr imm", mem_addr, 32'h1FFC);
        chk("R1 no wb", {31'd0, wb_en}, 0);
        off_sel_reg = 1; off_reg_val = 32'h3; off_shift = 2; #1;
        chk("R2 reg<<2", mem_addr, 32'h100C);
        off_reg_val = 32'h4000_0001; off_shift = 3; #1;
        chk("R2 reg<<3", mem_addr, 32'h0000_1008);
        off_sel_reg = 0; off_imm = 12'h10; req_sub = 1; #1;
        chk("R3 sub", mem_addr, 32'h0FF0);
        base_val = 32'h4; off_imm = 12'h8; #1;
        chk("R3 sub wrap", mem_addr, 32'hFFFF_FFFC);
    endtask

    task automatic t_pre_post();
        @(negedge clk); idle();
        req_valid = 1; req_load = 1; req_mode = 1; base_val = 32'h2000; off_imm = 12'h20; #1;
        chk("R4 addr", mem_addr, 32'h2020);
        chk("R4 wb_en", {31'd0, wb_en}, 1);
        chk("R4 wb_value", wb_value, 32'h2020);
        req_mode = 2; off_imm = 12'h0C; #1;
        chk("R5 addr", mem_addr, 32'h2000);
        chk("R5 wb_en", {31'd0, wb_en}, 1);
        chk("R5 wb_value", wb_value, 32'h200C);
        req_sub = 1; #1;
        chk("R5 wb sub", wb_value, 32'h1FF4);
    endtask

    task automatic t_store_lanes();
        @(negedge clk); idle();
        req_valid = 1; req_load = 0; req_size = 1; base_val = 32'h3001; st_lo = 32'hDEAD_BE5A; #1;
        chk("R6 byte be lane1", {28'd0, mem_be}, 32'h2);
        chk("R8 byte rep", mem_wdata, 32'h5A5A_5A5A);
        base_val = 32'h3003; #1;
        chk("R6 byte be lane3", {28'd0, mem_be}, 32'h8);
        req_size = 3; base_val = 32'h3002; #1;
        chk("R6 half be hi", {28'd0, mem_be}, 32'hC);
        chk("R8 half rep", mem_wdata, 32'hBE5A_BE5A);
        base_val = 32'h3000; #1;
        chk("R6 half be lo", {28'd0, mem_be}, 32'h3);
        req_size = 0; #1;
        chk("R6 word be", {28'd0, mem_be}, 32'hF);
        chk("R6 word we", {31'd0, mem_we}, 1);
        req_load = 1; #1;
        chk("R6 load be zero", {28'd0, mem_be}, 0);
    endtask

    task automatic t_load_ext();
        @(negedge clk); idle();
        req_valid = 1; req_load = 1; mem_rdata = 32'h80C3_8001; base_val = 32'h4003;
        req_size = 2; #1; chk("R7 sbyte neg", ld_value, 32'hFFFF_FF80);
        req_size = 1; #1; chk("R7 ubyte", ld_value, 32'h0000_0080);
        base_val = 32'h4000; req_size = 2; #1; chk("R7 sbyte pos", ld_value, 32'h0000_0001);
        req_size = 4; #1; chk("R7 shalf lo", ld_value, 32'hFFFF_8001);
        req_size = 3; #1; chk("R7 uhalf lo", ld_value, 32'h0000_8001);
        base_val = 32'h4002; req_size = 4; #1; chk("R7 shalf hi", ld_value, 32'hFFFF_80C3);
        req_size = 0; #1; chk("R7 word", ld_value, 32'h80C3_8001);
    endtask

    task automatic t_dword_store();
        @(negedge clk); idle();
        req_valid = 1; req_load = 0; req_size = 5; base_val = 32'h5000; off_imm = 12'h8;
        st_lo = 32'h1111_2222; st_hi = 32'h3333_4444; #1;
        chk("R9 lo addr", mem_addr, 32'h5008);
        chk("R9 lo data", mem_wdata, 32'h1111_2222);
        chk("R9 lo be", {28'd0, mem_be}, 32'hF);
        chk("R9 lo busy", {31'd0, busy}, 0);
        @(negedge clk);
        base_val = 32'h9000; req_mode = 1; req_size = 1; st_hi = 32'hFFFF_FFFF; st_lo = 0; #1;
        chk("R9 hi busy", {31'd0, busy}, 1);
        chk("R9 hi addr", mem_addr, 32'h500C);
        chk("R9 hi data", mem_wdata, 32'h3333_4444);
        chk("R9 hi be", {28'd0, mem_be}, 32'hF);
        chk("R10 no wb", {31'd0, wb_en}, 0);
        @(negedge clk); req_valid = 0; #1;
        chk("R10 dropped busy", {31'd0, busy}, 0);
        chk("R10 dropped en", {31'd0, mem_en}, 0);
    endtask

    task automatic t_dword_load();
        @(negedge clk); idle();
        req_valid = 1; req_load = 1; req_size = 5; req_mode = 1; base_val = 32'h6000;
        off_imm = 12'h10; mem_rdata = 32'hAAAA_0001; #1;
        chk("R9 ld lo val", ld_value, 32'hAAAA_0001);
        chk("R4 dw wb", wb_value, 32'h6010);
        chk("R4 dw wb_en", {31'd0, wb_en}, 1);
        @(negedge clk); req_valid = 0; mem_rdata = 32'hBBBB_0002; #1;
        chk("R9 ld hi addr", mem_addr, 32'h6014);
        chk("R9 ld hi val", ld_value, 32'hBBBB_0002);
        chk("R9 ld hi we", {31'd0, mem_we}, 0);
        chk("R9 ld hi be", {28'd0, mem_be}, 0);
        @(negedge clk); #1;
        chk("R9 busy clears", {31'd0, busy}, 0);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_offset();
        t_pre_post();
        t_store_lanes();
        t_load_ext();
        t_dword_store();
        t_dword_load();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule